// File: doc/BRIEF.md
# Input Protection Switch Sequencer

This block is the digital controller behind the analog comparators of an input protection switch. It takes three fault indications (input too low, input too high, die too hot) and an active-high shutdown request. From these it drives a gate command for the series power switch and an active-low fault flag. Every input passes through a two-flop synchronizer. Both outputs are registered.

When the input becomes valid, the block waits a programmable start-up delay and then checks the shutdown request. If shutdown is low, it closes the switch. A second programmable delay follows before the flag is released high. If shutdown is high, the switch stays open, but the flag goes high at once, because the flag follows input validity and ignores shutdown. Any fault opens the switch and pulls the flag low one cycle after the synchronizer sees it. The timer then clears, so recovery always starts the full sequence again. Both delays are counted in clock cycles. At 250 MHz, the default of 7,500,000 cycles gives 30 ms.

Top module: `pwrsw_seq_ctrl`

## Requirements
- R1: A synchronous reset held high drives gate_on low and fault_n low, and clears both delay timers. After reset, the full start-up sequence runs again.
- R2: When any of uv_det, ov_det or ot_det is 1 at a clock edge, gate_on is 0 and fault_n is 0 from the third clock edge after it. This holds for any value of shdn.
- R3: Once all three fault inputs are 0, gate_on stays 0 for ON_DLY_CYC cycles of the start-up state. The start-up state begins three edges after the inputs are first seen valid.
- R4: A fault that appears before the start-up delay completes returns the block to the fault state. The start-up delay then restarts from zero when the fault clears.
- R5: With shdn 0, the switch closes when the start-up delay completes, while fault_n is still 0. fault_n rises exactly FLAG_DLY_CYC cycles later. A fault during that wait opens the switch and keeps fault_n low.
- R6: When the start-up delay completes with shdn 1, gate_on stays 0 and fault_n goes 1.
- R7: shdn held 0 never closes the switch or raises fault_n while a fault is present.
- R8: When shdn goes to 1 while the switch is closed, gate_on falls on the third edge after it. fault_n stays 1 if the switch was already in the run state.
- R9: When shdn returns to 0 from the open-but-valid state, the switch closes immediately, fault_n drops to 0, and the flag delay restarts from zero.
- R10: An over-temperature fault behaves like a voltage fault. Once it clears, the full start-up delay runs again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both delays are counted in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| uv_det | input | 1 | 1 when the supply is below the low threshold |
| ov_det | input | 1 | 1 when the supply is above the high threshold |
| ot_det | input | 1 | 1 when the die is over temperature |
| shdn | input | 1 | 1 requests the switch open |
| gate_on | output | 1 | 1 commands the power switch closed |
| fault_n | output | 1 | 0 signals a fault or a pending start-up |

## Verification
The hardest case to reach from the ports is re-arming from the open-but-valid state. The block must first complete a full start-up delay with shdn high. shdn must then fall with no fault present, and the flag delay must restart from zero rather than resume. Directed sequences drive the block through that path, and also inject faults one cycle before each delay would expire. A long random run then uses long valid stretches, so that both timers often expire between short fault pulses and shutdown toggles. A cycle-exact reference model in the bench predicts both outputs on every cycle.

// File: rtl/pwrsw_pkg.sv
package pwrsw_pkg;
  typedef enum logic [2:0] {
    PH_FAULT = 3'd0,
    PH_START = 3'd1,
    PH_FWAIT = 3'd2,
    PH_RUN   = 3'd3,
    PH_OFF   = 3'd4
  } ph_t;

  function automatic logic gate_of(ph_t p);
    return (p == PH_FWAIT) || (p == PH_RUN);
  endfunction

  function automatic logic flag_of(ph_t p);
    return (p == PH_RUN) || (p == PH_OFF);
  endfunction
endpackage

// File: rtl/pwrsw_sync.sv
module pwrsw_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= RST_VAL;
      q  <= RST_VAL;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/pwrsw_dly_timer.sv
module pwrsw_dly_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
endmodule

// File: rtl/pwrsw_ctrl_fsm.sv
module pwrsw_ctrl_fsm
  import pwrsw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fault,
  input  logic en_off,
  input  logic on_done,
  input  logic fl_done,
  output ph_t  state,
  output logic gate_q,
  output logic flag_q
);
  ph_t nxt;

  always_comb begin
    nxt = state;
    if (fault) nxt = PH_FAULT;
    else begin
      unique case (state)
        PH_FAULT: nxt = PH_START;
        PH_START: if (on_done) nxt = en_off ? PH_OFF : PH_FWAIT;
        PH_FWAIT: if (en_off) nxt = PH_OFF;
                  else if (fl_done) nxt = PH_RUN;
        PH_RUN:   if (en_off) nxt = PH_OFF;
        PH_OFF:   if (!en_off) nxt = PH_FWAIT;
        default:  nxt = PH_FAULT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= PH_FAULT;
      gate_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      state  <= nxt;
      gate_q <= gate_of(nxt);
      flag_q <= flag_of(nxt);
    end
  end

  // R2
  fault_gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    fault |=> (!gate_q && !flag_q));
  // R8
  shdn_open_chk: assert property (@(posedge clk) disable iff (rst)
    en_off |=> !gate_q);
  // R5
  flag_after_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q) |-> !flag_q);
  // R6
  off_flag_high_chk: assert property (@(posedge clk) disable iff (rst)
    (state == PH_OFF && !fault && en_off) |=> (flag_q && !gate_q));
  // R9
  rearm_chk: assert property (@(posedge clk) disable iff (rst)
    (state == PH_OFF && !fault && !en_off) |=> (gate_q && !flag_q));
endmodule

// File: rtl/pwrsw_seq_ctrl.sv
module pwrsw_seq_ctrl
  import pwrsw_pkg::*;
#(
  parameter int ON_DLY_CYC   = 7500000,
  parameter int FLAG_DLY_CYC = 7500000
) (
  input  logic clk,
  input  logic rst,
  input  logic uv_det,
  input  logic ov_det,
  input  logic ot_det,
  input  logic shdn,
  output logic gate_on,
  output logic fault_n
);
  localparam int NIN = 4;

  logic [NIN-1:0] raw_in, syn_in;
  logic fault_s, en_off_s, on_done, fl_done;
  ph_t  state;

  assign raw_in = {shdn, ot_det, ov_det, uv_det};

  pwrsw_sync #(.W(NIN), .RST_VAL('1)) sync_i (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn_in)
  );

  assign fault_s  = |syn_in[2:0];
  assign en_off_s = syn_in[3];

  pwrsw_dly_timer #(.LIMIT(ON_DLY_CYC)) on_tmr_i (
    .clk(clk), .rst(rst), .run(state == PH_START), .done(on_done)
  );

  pwrsw_dly_timer #(.LIMIT(FLAG_DLY_CYC)) fl_tmr_i (
    .clk(clk), .rst(rst), .run(state == PH_FWAIT), .done(fl_done)
  );

  pwrsw_ctrl_fsm fsm_i (
    .clk(clk), .rst(rst), .fault(fault_s), .en_off(en_off_s),
    .on_done(on_done), .fl_done(fl_done),
    .state(state), .gate_q(gate_on), .flag_q(fault_n)
  );

  // R7
  no_close_in_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_s && !en_off_s) |=> !fault_n);
endmodule

// File: tb/pwrsw_seq_ctrl_tb.sv
module pwrsw_seq_ctrl_tb_top;
  localparam int ON_D = 12;
  localparam int FL_D = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic uv = 1'b0, ov = 1'b0, ot = 1'b0, sd = 1'b0;
  logic gate_on, fault_n;

  int n_chk = 0;
  int n_err = 0;

  // model state: 0 fault, 1 startup, 2 flag wait, 3 run, 4 valid-off
  int m_ph = 0;
  int m_elapsed = 0;
  logic [3:0] m_a = '1, m_b = '1;

  always #2 clk = ~clk;

  pwrsw_seq_ctrl #(.ON_DLY_CYC(ON_D), .FLAG_DLY_CYC(FL_D)) dut_i (
    .clk(clk), .rst(rst), .uv_det(uv), .ov_det(ov), .ot_det(ot),
    .shdn(sd), .gate_on(gate_on), .fault_n(fault_n)
  );

  function automatic int next_ph(int ph, int el, logic flt, logic off);
    if (flt) return 0;
    case (ph)
      0: return 1;
      1: return (el + 1 >= ON_D) ? (off ? 4 : 2) : 1;
      2: return off ? 4 : ((el + 1 >= FL_D) ? 3 : 2);
      3: return off ? 4 : 3;
      default: return off ? 4 : 2;
    endcase
  endfunction

  function automatic logic exp_gate(int ph);
    return ph == 2 || ph == 3;
  endfunction

  function automatic logic exp_flag(int ph);
    return ph == 3 || ph == 4;
  endfunction

  task automatic step(input logic r, input logic u, input logic o,
                      input logic t, input logic s, input string tag);
    int np;
    @(negedge clk);
    rst = r; uv = u; ov = o; ot = t; sd = s;
    @(posedge clk);
    if (r) begin
      m_ph = 0; m_elapsed = 0; m_a = '1; m_b = '1;
    end else begin
      np = next_ph(m_ph, m_elapsed, |m_b[2:0], m_b[3]);
      m_elapsed = (np == m_ph) ? m_elapsed + 1 : 0;
      m_ph = np;
      m_b = m_a;
      m_a = {s, t, o, u};
    end
    #1;
    n_chk++;
    if (gate_on !== exp_gate(m_ph) || fault_n !== exp_flag(m_ph)) begin
      n_err++;
      $display("FAIL %s: gate_on=%b fault_n=%b expected gate_on=%b fault_n=%b",
               tag, gate_on, fault_n, exp_gate(m_ph), exp_flag(m_ph));
    end
  endtask

  task automatic hold(input int n, input logic u, input logic o,
                      input logic t, input logic s, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, u, o, t, s, tag);
  endtask

  function automatic string tag_of(int ph);
    case (ph)
      0: return "R2";
      1: return "R4";
      2: return "R5";
      3: return "R8";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #800000;
    n_err++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int len;
    logic u, o, t, s;
    void'($urandom(32'd20240611));
    // R1 reset state
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    // R3 start-up delay, then R5 flag delay
    hold(ON_D + 3, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    hold(FL_D + 6, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    // R10 thermal fault and full restart
    hold(2, 1'b0, 1'b0, 1'b1, 1'b0, "R10");
    hold(ON_D + FL_D + 8, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
    // R4 fault one cycle before start-up completes
    hold(3, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
    hold(ON_D + 2, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    hold(1, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
    hold(ON_D + 5, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    // R5 fault during flag wait
    hold(2, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
    hold(ON_D + FL_D + 8, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    // R8 shutdown while running
    hold(6, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
    // R7 fault with shutdown low must not close
    hold(6, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    hold(4, 1'b1, 1'b0, 1'b0, 1'b1, "R7");
    // R6 start-up completes with shutdown high
    hold(ON_D + 6, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
    // R9 re-arm from valid-off, flag delay restarts
    hold(FL_D + 5, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    hold(3, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
    hold(FL_D - 3, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    hold(3, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
    hold(FL_D + 5, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    // R1 reset mid-run
    hold(2, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    hold(ON_D + 4, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    // random phase
    for (int k = 0; k < 400; k++) begin
      len = ($urandom % 4 == 0) ? 1 + $urandom % 4 : 1 + $urandom % (ON_D + FL_D + 6);
      u = ($urandom % 9 == 0);
      o = ($urandom % 9 == 0);
      t = ($urandom % 12 == 0);
      s = ($urandom % 4 == 0);
      for (int j = 0; j < len; j++)
        step(1'b0, u, o, t, s, tag_of(m_ph));
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule